// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block is the memory-access stage for a data memory organised as 32-bit words. Each cycle it may take one operation: a 7-bit opcode, a 32-bit base register value, a signed offset and a 32-bit store operand. It adds the base and the offset to form the effective address. It then either issues a word-addressed write with per-byte enables, or issues a read and shapes the returned word into a register value.

The memory behind it is a single-cycle synchronous RAM. The request leaves the block in the same cycle as the operation. For a load, the read word comes back in the next cycle, and the block picks out the addressed byte or halfword and sign- or zero-extends it at that point. A prefetch issues an address without writing memory or a register. Reserved opcodes and misaligned accesses make no memory request at all. A misaligned access also raises a flag.

Byte lanes are numbered big-endian by default: the byte at address offset 0 is data bits 31:24. A parameter selects little-endian numbering instead.

Top module: `lsu_align`

## Requirements
- R1: For every load, store and prefetch, the effective address is `base` plus `offset` sign-extended to 32 bits, and `mem_addr` carries its bits [ADDR_W+1:2] in the same cycle.
- R2: A word load (opcode 0010001) makes a read request with `mem_we`=0. One cycle later `ld_valid` is 1 for exactly one cycle, and `ld_data` equals the whole returned word.
- R3: Halfword loads (0010010 sign-extends, 0010011 zero-extends) take bits 31:16 of the returned word when address bit 1 is 0, and bits 15:0 when it is 1.
- R4: Byte loads (0010100 sign-extends, 0010101 zero-extends) take the lane given by address bits [1:0]: 00 gives bits 31:24, 01 gives 23:16, 10 gives 15:8 and 11 gives 7:0.
- R5: Stores (0010110 word, 0010111 halfword, 0011000 byte) assert `mem_req` and `mem_we`. `mem_wdata` holds the low byte of `st_data` four times, the low halfword twice, or the full word. `byte_en[i]` enables `mem_wdata[8i+7:8i]`. The enables are 1111 for a word, 1100 or 0011 for a halfword (address bit 1 = 0 or 1), and 1000 shifted right by address bits [1:0] for a byte.
- R6: A prefetch (0011001) asserts `mem_req` with `mem_we`=0 and `byte_en`=0000 at any alignment. It never raises `misalign`, and `ld_valid` stays 0 in the following cycle.
- R7: Reserved opcodes (0010000, 0011010, 0011011, 0011101, 0011110) and every opcode outside the load/store/prefetch set make no request, raise no `misalign`, and cause no `ld_valid`.
- R8: A halfword load or store with address bit 0 set, or a word load or store with address bits [1:0] not 00, raises `misalign` in that cycle. It makes no memory request, so memory is unchanged, and it causes no `ld_valid`.
- R9: While reset is held and in the first cycle after it, `ld_valid` is 0. While `op_valid` is 0, `mem_req` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 7 | Operation code |
| base | input | 32 | Base register value |
| offset | input | OFS_W | Signed address offset |
| st_data | input | 32 | Store operand (second register) |
| mem_rdata | input | 32 | Word returned by memory one cycle after a read request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| byte_en | output | 4 | Byte write enables, bit i covers data bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-replicated write data |
| misalign | output | 1 | Access is not aligned to its size |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
The opcode input is swept over all 128 codes at an aligned address. This separates the five load encodings, three store encodings, the prefetch, the reserved codes and the codes from other operation groups by whether a request, a write and a load return appear. Each load encoding is then run at every byte offset of sixteen words whose contents have mixed sign bits, using a negative offset. This tells sign from zero extension, upper from lower halfword, the four byte lanes, and aligned from misaligned cases. Each store size is run at every byte offset and followed by a word read-back, which shows that only the enabled lanes changed and that misaligned stores left memory untouched. Prefetches at odd addresses confirm that they are never flagged.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   localparam int DATA_W = 32;
   localparam int NLANE  = DATA_W / 8;
   localparam int OPC_W  = 7;

   localparam logic [OPC_W-1:0] OPC_LD_W   = 7'b0010001;
   localparam logic [OPC_W-1:0] OPC_LD_HS  = 7'b0010010;
   localparam logic [OPC_W-1:0] OPC_LD_HU  = 7'b0010011;
   localparam logic [OPC_W-1:0] OPC_LD_BS  = 7'b0010100;
   localparam logic [OPC_W-1:0] OPC_LD_BU  = 7'b0010101;
   localparam logic [OPC_W-1:0] OPC_ST_W   = 7'b0010110;
   localparam logic [OPC_W-1:0] OPC_ST_H   = 7'b0010111;
   localparam logic [OPC_W-1:0] OPC_ST_B   = 7'b0011000;
   localparam logic [OPC_W-1:0] OPC_PREF   = 7'b0011001;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_PREF  = 2'd3
   } acc_kind_t;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2
   } acc_size_t;

   typedef struct packed {
      acc_kind_t kind;
      acc_size_t size;
      logic      sgn;
   } acc_dec_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
(
   input  logic [OPC_W-1:0] op_code,
   output acc_dec_t         dec
);

   always_comb begin
      dec = '{kind: ACC_NONE, size: SZ_W, sgn: 1'b0};
      case (op_code)
         OPC_LD_W:  dec = '{kind: ACC_LOAD,  size: SZ_W, sgn: 1'b0};
         OPC_LD_HS: dec = '{kind: ACC_LOAD,  size: SZ_H, sgn: 1'b1};
         OPC_LD_HU: dec = '{kind: ACC_LOAD,  size: SZ_H, sgn: 1'b0};
         OPC_LD_BS: dec = '{kind: ACC_LOAD,  size: SZ_B, sgn: 1'b1};
         OPC_LD_BU: dec = '{kind: ACC_LOAD,  size: SZ_B, sgn: 1'b0};
         OPC_ST_W:  dec = '{kind: ACC_STORE, size: SZ_W, sgn: 1'b0};
         OPC_ST_H:  dec = '{kind: ACC_STORE, size: SZ_H, sgn: 1'b0};
         OPC_ST_B:  dec = '{kind: ACC_STORE, size: SZ_B, sgn: 1'b0};
         OPC_PREF:  dec = '{kind: ACC_PREF,  size: SZ_B, sgn: 1'b0};
         default:   dec = '{kind: ACC_NONE,  size: SZ_W, sgn: 1'b0};
      endcase
   end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_pkg::*;
#(
   parameter int OFS_W  = 12,
   parameter int ADDR_W = 30
) (
   input  logic [DATA_W-1:0] base,
   input  logic [OFS_W-1:0]  offset,
   input  acc_size_t         size,
   output logic [DATA_W-1:0] ea,
   output logic [ADDR_W-1:0] word_addr,
   output logic              unaligned
);

   logic [DATA_W-1:0] ofs_x;

   generate
      if (OFS_W == DATA_W) begin : g_full_ofs
         assign ofs_x = offset;
      end else begin : g_ext_ofs
         assign ofs_x = {{(DATA_W-OFS_W){offset[OFS_W-1]}}, offset};
      end
   endgenerate

   assign ea        = base + ofs_x;
   assign word_addr = ea[ADDR_W+1:2];

   always_comb begin
      case (size)
         SZ_W:    unaligned = |ea[1:0];
         SZ_H:    unaligned = ea[0];
         default: unaligned = 1'b0;
      endcase
   end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [DATA_W-1:0] src,
   input  logic [1:0]        lane,
   input  acc_size_t         size,
   output logic [NLANE-1:0]  be,
   output logic [DATA_W-1:0] wdata
);

   logic [1:0] phys;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign phys = ~lane;
      end else begin : g_little
         assign phys = lane;
      end
   endgenerate

   always_comb begin
      case (size)
         SZ_W: begin
            be    = '1;
            wdata = src;
         end
         SZ_H: begin
            be    = 4'b0011 << {phys[1], 1'b0};
            wdata = {2{src[15:0]}};
         end
         default: begin
            be    = 4'b0001 << phys;
            wdata = {NLANE{src[7:0]}};
         end
      endcase
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [DATA_W-1:0] word,
   input  logic [1:0]        lane,
   input  acc_size_t         size,
   input  logic              sgn,
   output logic [DATA_W-1:0] data
);

   logic [4:0]  b_sh;
   logic [4:0]  h_sh;
   logic [7:0]  b_val;
   logic [15:0] h_val;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign b_sh = {~lane, 3'b000};
         assign h_sh = {~lane[1], 4'b0000};
      end else begin : g_little
         assign b_sh = {lane, 3'b000};
         assign h_sh = {lane[1], 4'b0000};
      end
   endgenerate

   assign b_val = 8'(word >> b_sh);
   assign h_val = 16'(word >> h_sh);

   always_comb begin
      case (size)
         SZ_W:    data = word;
         SZ_H:    data = {{16{sgn & h_val[15]}}, h_val};
         default: data = {{24{sgn & b_val[7]}}, b_val};
      endcase
   end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
   import lsu_pkg::*;
#(
   parameter int OFS_W      = 12,
   parameter int ADDR_W     = 30,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [6:0]        op_code,
   input  logic [31:0]       base,
   input  logic [OFS_W-1:0]  offset,
   input  logic [31:0]       st_data,
   input  logic [31:0]       mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        byte_en,
   output logic [31:0]       mem_wdata,
   output logic              misalign,
   output logic              ld_valid,
   output logic [31:0]       ld_data
);

   generate
      if (OFS_W < 1 || OFS_W > DATA_W) begin : g_bad_ofs
         $error("lsu_align: OFS_W must lie in 1..32");
      end
      if (ADDR_W < 1 || ADDR_W > DATA_W - 2) begin : g_bad_addr
         $error("lsu_align: ADDR_W must lie in 1..30");
      end
   endgenerate

   acc_dec_t          dec;
   logic [DATA_W-1:0] ea;
   logic              unaligned;
   logic [NLANE-1:0]  st_be;
   logic [DATA_W-1:0] ext_data;
   logic              acc_go;
   logic              size_checked;

   logic              ld_pend;
   acc_size_t         ld_size;
   logic              ld_sgn;
   logic [1:0]        ld_lane;

   lsu_decode u_dec (
      .op_code (op_code),
      .dec     (dec)
   );

   lsu_agen #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_agen (
      .base      (base),
      .offset    (offset),
      .size      (dec.size),
      .ea        (ea),
      .word_addr (mem_addr),
      .unaligned (unaligned)
   );

   lsu_store_steer #(.BIG_ENDIAN(BIG_ENDIAN)) u_steer (
      .src   (st_data),
      .lane  (ea[1:0]),
      .size  (dec.size),
      .be    (st_be),
      .wdata (mem_wdata)
   );

   // Request side: same cycle as the operation.
   assign acc_go       = op_valid && (dec.kind != ACC_NONE);
   assign size_checked = (dec.kind == ACC_LOAD) || (dec.kind == ACC_STORE);
   assign misalign     = acc_go && size_checked && unaligned;
   assign mem_req      = acc_go && !misalign;
   assign mem_we       = mem_req && (dec.kind == ACC_STORE);
   assign byte_en      = mem_we ? st_be : '0;

   // Load context travels one cycle alongside the synchronous read.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_pend <= 1'b0;
         ld_size <= SZ_W;
         ld_sgn  <= 1'b0;
         ld_lane <= 2'b00;
      end else begin
         ld_pend <= mem_req && (dec.kind == ACC_LOAD);
         if (mem_req && (dec.kind == ACC_LOAD)) begin
            ld_size <= dec.size;
            ld_sgn  <= dec.sgn;
            ld_lane <= ea[1:0];
         end
      end
   end

   lsu_load_extract #(.BIG_ENDIAN(BIG_ENDIAN)) u_ext (
      .word (mem_rdata),
      .lane (ld_lane),
      .size (ld_size),
      .sgn  (ld_sgn),
      .data (ext_data)
   );

   assign ld_valid = ld_pend;
   assign ld_data  = ld_pend ? ext_data : '0;

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
   import lsu_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       op_valid,
   input logic [6:0] op_code,
   input logic       mem_req,
   input logic       mem_we,
   input logic [3:0] byte_en,
   input logic       misalign,
   input logic       ld_valid
);

   logic in_group;
   logic is_load;
   logic ld_issue;

   assign in_group = (op_code >= OPC_LD_W) && (op_code <= OPC_PREF);
   assign is_load  = (op_code >= OPC_LD_W) && (op_code <= OPC_LD_BU);
   assign ld_issue = op_valid && mem_req && !mem_we && is_load;

   p_load_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_issue |=> ld_valid);

   p_no_spurious_ld_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_issue |=> !ld_valid);

   p_store_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($countones(byte_en) == 1 || $countones(byte_en) == 2 ||
                  byte_en == 4'b1111));

   p_pref_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OPC_PREF) |-> (mem_req && !mem_we && byte_en == 4'b0000 && !misalign));

   p_outside_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !in_group) |-> (!mem_req && !misalign));

   p_misalign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_req && !mem_we && byte_en == 4'b0000));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!mem_req && !misalign));

endmodule

bind lsu_align lsu_align_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .byte_en  (byte_en),
   .misalign (misalign),
   .ld_valid (ld_valid)
);

// File: tb/sim_lsu_align.sv
module sim_lsu_align;

   localparam int OFS_W  = 12;
   localparam int ADDR_W = 30;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              op_valid;
   logic [6:0]        op_code;
   logic [31:0]       base;
   logic [OFS_W-1:0]  offset;
   logic [31:0]       st_data;
   logic [31:0]       mem_rdata;
   logic              mem_req;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [3:0]        byte_en;
   logic [31:0]       mem_wdata;
   logic              misalign;
   logic              ld_valid;
   logic [31:0]       ld_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] ram    [16];
   logic [31:0] shadow [16];

   always #4 clk = ~clk;

   lsu_align u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .base(base), .offset(offset), .st_data(st_data), .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .byte_en(byte_en),
      .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
   );

   function automatic logic [31:0] init_word(int i);
      return 32'(32'h9E37_79B9 * (i + 1)) ^ 32'(i << 12);
   endfunction

   // Memory model: single-cycle synchronous read, byte-enabled write.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) ram[i] <= init_word(i);
         mem_rdata <= '0;
      end else begin
         if (mem_req && !mem_we) mem_rdata <= ram[mem_addr[3:0]];
         if (mem_we)
            for (int i = 0; i < 4; i++)
               if (byte_en[i]) ram[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end
   end

   // 0 other, 1 load, 2 store, 3 prefetch
   function automatic int kind_of(logic [6:0] op);
      if (op >= 7'b0010001 && op <= 7'b0010101) return 1;
      if (op >= 7'b0010110 && op <= 7'b0011000) return 2;
      if (op == 7'b0011001) return 3;
      return 0;
   endfunction

   // 0 byte, 1 halfword, 2 word
   function automatic int size_of(logic [6:0] op);
      case (op)
         7'b0010001, 7'b0010110:             return 2;
         7'b0010010, 7'b0010011, 7'b0010111: return 1;
         default:                            return 0;
      endcase
   endfunction

   function automatic logic [31:0] exp_load(logic [6:0] op, logic [31:0] w, logic [1:0] ln);
      logic [15:0] h;
      logic [7:0]  b;
      h = ln[1] ? w[15:0] : w[31:16];
      b = 8'(w >> (8 * (3 - int'(ln))));
      case (op)
         7'b0010001: return w;
         7'b0010010: return {{16{h[15]}}, h};
         7'b0010011: return {16'h0, h};
         7'b0010100: return {{24{b[7]}}, b};
         default:    return {24'h0, b};
      endcase
   endfunction

   function automatic logic [3:0] exp_be(int sz, logic [1:0] ln);
      if (sz == 2) return 4'b1111;
      if (sz == 1) return ln[1] ? 4'b0011 : 4'b1100;
      return 4'b1000 >> ln;
   endfunction

   function automatic logic [31:0] exp_wd(int sz, logic [31:0] d);
      if (sz == 2) return d;
      if (sz == 1) return {d[15:0], d[15:0]};
      return {d[7:0], d[7:0], d[7:0], d[7:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic [6:0] op, input logic [31:0] b,
                        input logic [OFS_W-1:0] off, input logic [31:0] sd);
      int          k;
      int          sz;
      logic [31:0] ea;
      bit          mis;
      int          idx;
      logic [3:0]  be;
      logic [31:0] wd;
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = op;
      base     = b;
      offset   = off;
      st_data  = sd;
      #1;
      ea  = b + {{(32-OFS_W){off[OFS_W-1]}}, off};
      k   = kind_of(op);
      sz  = size_of(op);
      mis = (k == 1 || k == 2) && ((sz == 2 && ea[1:0] != 2'b00) || (sz == 1 && ea[0]));
      idx = int'(ea[5:2]);
      be  = exp_be(sz, ea[1:0]);
      wd  = exp_wd(sz, sd);
      if (k == 0) begin
         chk(!mem_req && !misalign, "R7 reserved/other opcode makes no request",
             {30'h0, mem_req, misalign}, 32'h0);
      end else if (mis) begin
         chk(misalign && !mem_req && !mem_we, "R8 misaligned access flagged, no request",
             {29'h0, misalign, mem_req, mem_we}, 32'h4);
      end else begin
         chk(mem_req && !misalign, "R1 request issued", {30'h0, mem_req, misalign}, 32'h2);
         chk(mem_addr == ea[31:2], "R1 word address", 32'(mem_addr), 32'(ea[31:2]));
         if (k == 2) begin
            chk(mem_we, "R5 store write strobe", 32'(mem_we), 32'h1);
            chk(byte_en == be, "R5 store byte enables", 32'(byte_en), 32'(be));
            chk(mem_wdata == wd, "R5 store lane data", mem_wdata, wd);
            for (int i = 0; i < 4; i++)
               if (be[i]) shadow[idx][8*i +: 8] = wd[8*i +: 8];
         end else if (k == 3) begin
            chk(!mem_we && byte_en == 4'b0000, "R6 prefetch writes nothing",
                {27'h0, mem_we, byte_en}, 32'h0);
         end else begin
            chk(!mem_we && byte_en == 4'b0000, "R2 load is a read",
                {27'h0, mem_we, byte_en}, 32'h0);
         end
      end
      @(negedge clk);
      op_valid = 1'b0;
      #1;
      if (k == 1 && !mis) begin
         if (sz == 2)
            chk(ld_valid && ld_data == exp_load(op, shadow[idx], ea[1:0]), "R2 word load result",
                ld_data, exp_load(op, shadow[idx], ea[1:0]));
         else if (sz == 1)
            chk(ld_valid && ld_data == exp_load(op, shadow[idx], ea[1:0]), "R3 halfword load result",
                ld_data, exp_load(op, shadow[idx], ea[1:0]));
         else
            chk(ld_valid && ld_data == exp_load(op, shadow[idx], ea[1:0]), "R4 byte load result",
                ld_data, exp_load(op, shadow[idx], ea[1:0]));
      end else if (k == 3) begin
         chk(!ld_valid, "R6 prefetch returns no load", 32'(ld_valid), 32'h0);
      end else if (mis) begin
         chk(!ld_valid, "R8 misaligned access returns no load", 32'(ld_valid), 32'h0);
      end else begin
         chk(!ld_valid, "R7 non-load returns no load", 32'(ld_valid), 32'h0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog expired act=%h exp=%h", 32'h0, 32'h1);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [6:0] ld_ops [5];
      logic [6:0] st_ops [3];
      int         words  [3];
      ld_ops = '{7'b0010001, 7'b0010010, 7'b0010011, 7'b0010100, 7'b0010101};
      st_ops = '{7'b0010110, 7'b0010111, 7'b0011000};
      words  = '{3, 7, 12};
      for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
      rst_n    = 1'b0;
      op_valid = 1'b0;
      op_code  = 7'b0010001;
      base     = '0;
      offset   = '0;
      st_data  = '0;
      repeat (3) @(posedge clk);
      #1;
      chk(!ld_valid, "R9 no load result during reset", 32'(ld_valid), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!ld_valid && !mem_req && !misalign, "R9 quiet after reset",
          {29'h0, ld_valid, mem_req, misalign}, 32'h0);

      // Every opcode at an aligned address.
      for (int o = 0; o < 128; o++)
         do_op(7'(o), 32'h0000_0100, 12'h004, 32'hA5C3_5A3C);

      // Every load encoding at every byte offset, negative offset operand.
      for (int w = 0; w < 16; w++)
         for (int ln = 0; ln < 4; ln++)
            for (int j = 0; j < 5; j++)
               do_op(ld_ops[j], 32'h0000_2000 + 32'(w * 4 + ln) + 32'd700, 12'(-700), 32'h0);

      // Every store size at every byte offset, then a word read-back.
      for (int s = 0; s < 3; s++)
         for (int ln = 0; ln < 4; ln++)
            for (int q = 0; q < 3; q++) begin
               do_op(st_ops[s], 32'h0000_3000 + 32'(words[q] * 4 + ln) - 32'd5, 12'd5,
                     32'(32'h8102_F304 * (ln + 1)) ^ 32'(words[q] << 20));
               do_op(7'b0010001, 32'h0000_3000 + 32'(words[q] * 4), 12'd0, 32'h0);
            end

      // Prefetch at every byte offset.
      for (int ln = 0; ln < 4; ln++)
         do_op(7'b0011001, 32'h0000_0500 + 32'(ln), 12'hFFC, 32'h0);

      // Operation present on the bus but not valid.
      @(negedge clk);
      op_valid = 1'b0;
      op_code  = 7'b0010110;
      base     = 32'h0000_0001;
      #1;
      chk(!mem_req && !misalign, "R9 no request without op_valid",
          {30'h0, mem_req, misalign}, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule